// File: doc/BRIEF.md
# Adaptive Slope Delta Modulation Encoder

This block turns a stream of signed PCM samples into a one-bit delta-modulated stream. On every sampling tick it compares the current sample with an internal reconstruction value, emits a 1 when the sample is at or above that value and a 0 otherwise, and moves the reconstruction value up or down by an adaptive step. The step widens whenever the most recent output bits form a run of identical values, which signals slope overload. It shrinks back by a fractional leak toward a nonzero floor when no run is present. A select input picks between a short run (3 bits) and a long run (4 bits) as the trigger for widening.

Around the encoder sits a three-state controller. ST_QUIET is the powersave state, entered from reset or from any state when the awake input is low (transition "sleep"). It keeps the datapath cleared and pulls the output pin low. ST_RUN encodes normally. It is entered from ST_QUIET or ST_IDLE when awake is high and the force-idle input is high (transitions "wake-to-run" and "resume"). ST_IDLE ignores the sample and emits an alternating 0,1,0,1 pattern. It is entered from ST_QUIET or ST_RUN when awake is high and force-idle is low (transitions "wake-to-idle" and "pause"). The serial output is presented as three pin controls (data, drive enable, drive low), so a pad wrapper can build a three-state pin from them. The data-enable input lets several encoders share one line in a multiplexer.

Top module: `slope_delta_encoder`

## Requirements
- R1: On a clock edge with tick_i high in ST_RUN, the output bit becomes 1 if sample_i (signed) is greater than or equal to the integrator, else 0. It is visible on pin_data_o from that edge on, and without a tick it does not change.
- R2: On the same tick the integrator adds the step held before the tick when the bit is 1, or subtracts it when the bit is 0, saturating at the signed full-scale limits of SAMPLE_W bits.
- R3: A run is the newest bit together with the bits before it, all equal, counting only bits emitted since the history was last cleared. The run is 3 bits long when run3_sel_i is 1 and 4 bits long when it is 0.
- R4: On a tick with a run, the step grows by STEP_INC, capped at STEP_MAX. Without a run it becomes step - (step >> LEAK_SHIFT), floored at STEP_MIN. It always stays within [STEP_MIN, STEP_MAX].
- R5: While idle_n_i is low (ST_IDLE), samples are ignored and successive ticks emit 0,1,0,1,... starting with 0. The run history is empty, and the integrator and step hold their values.
- R6: On return to ST_RUN, encoding resumes from the held integrator and step, with an empty run history.
- R7: Outside ST_QUIET with drive_en_i high: pin_oe_o=1, pin_low_o=0 and pin_data_o carries the bit. With drive_en_i low: pin_oe_o=0 and pin_data_o=0. Encoding continues either way.
- R8: When awake_i is low, from the next cycle on pin_oe_o=1, pin_low_o=1 and pin_data_o=0, and ticks are ignored. On wake-up the integrator is 0 (midscale), the step is STEP_MIN, the history is empty and the output bit is 0.
- R9: While rst_n is low the block is in ST_QUIET, with the same pin values and cleared state as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sampling-clock enable, one output bit per high cycle |
| sample_i | input | SAMPLE_W | Signed PCM sample |
| run3_sel_i | input | 1 | 1: 3-bit run, 0: 4-bit run |
| idle_n_i | input | 1 | Low forces the alternating idle pattern |
| drive_en_i | input | 1 | Data enable; low releases the pin |
| awake_i | input | 1 | Low selects powersave |
| pin_data_o | output | 1 | Serial encoded bit |
| pin_oe_o | output | 1 | Pin drive enable |
| pin_low_o | output | 1 | Pin forced low (powersave) |

## Verification
The bench builds the encoder with SAMPLE_W=10, STEP_MIN=4, STEP_MAX=96, STEP_INC=24 and LEAK_SHIFT=2. With these values a few ticks of constant full-scale input drive the step to its cap, and the integrator to its saturation limit, within one short directed burst. A leak of a quarter also reaches the floor within a handful of ticks, so both the growth and the decay ends of the step range are hit often under random samples. The small sample width also means random inputs cross the integrator frequently, so both run lengths and both run polarities occur many times.

// File: rtl/sde_pkg.sv
package sde_pkg;
    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_RUN   = 2'd1,
        ST_IDLE  = 2'd2
    } sde_state_e;
endpackage

// File: rtl/sde_fsm.sv
module sde_fsm
    import sde_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       awake_i,
    input  logic       idle_n_i,
    input  logic       tick_i,
    output sde_state_e state_o,
    output logic       enc_fire_o,
    output logic       idle_fire_o,
    output logic       quiet_o
);
    sde_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_QUIET: if (awake_i) st_d = idle_n_i ? ST_RUN : ST_IDLE;
            ST_RUN: begin
                if (!awake_i)       st_d = ST_QUIET;
                else if (!idle_n_i) st_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!awake_i)      st_d = ST_QUIET;
                else if (idle_n_i) st_d = ST_RUN;
            end
            default: st_d = ST_QUIET;
        endcase
    end

    always_comb begin
        state_o     = st_q;
        enc_fire_o  = (st_q == ST_RUN)  && tick_i;
        idle_fire_o = (st_q == ST_IDLE) && tick_i;
        quiet_o     = (st_q == ST_QUIET);
    end
endmodule

// File: rtl/sde_run_detect.sv
module sde_run_detect #(
    parameter int RUN_LONG = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                shift_i,
    input  logic                bit_i,
    input  logic                short_sel_i,
    output logic                run_o,
    output logic [RUN_LONG-1:0] fill_o
);
    localparam int RUN_SHORT = RUN_LONG - 1;

    logic [RUN_LONG-1:0] hist_q, fill_q, hist_n, fill_n;
    logic run_short, run_long;

    assign hist_n = {hist_q[RUN_LONG-2:0], bit_i};
    assign fill_n = {fill_q[RUN_LONG-2:0], 1'b1};

    always_comb begin
        run_long  = (&fill_n) && ((&hist_n) || !(|hist_n));
        run_short = (&fill_n[RUN_SHORT-1:0]) &&
                    ((&hist_n[RUN_SHORT-1:0]) || !(|hist_n[RUN_SHORT-1:0]));
        run_o     = shift_i && (short_sel_i ? run_short : run_long);
        fill_o    = fill_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (clr_i) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (shift_i) begin
            hist_q <= hist_n;
            fill_q <= fill_n;
        end
    end
endmodule

// File: rtl/sde_step_adapt.sv
module sde_step_adapt #(
    parameter int STEP_MIN   = 16,
    parameter int STEP_MAX   = 1024,
    parameter int STEP_INC   = 64,
    parameter int LEAK_SHIFT = 4,
    parameter int STEP_W     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              upd_i,
    input  logic              run_i,
    output logic [STEP_W-1:0] step_o
);
    localparam logic [STEP_W:0]   INC_X = (STEP_W+1)'(STEP_INC);
    localparam logic [STEP_W:0]   MAX_X = (STEP_W+1)'(STEP_MAX);
    localparam logic [STEP_W-1:0] MIN_V = STEP_W'(STEP_MIN);
    localparam logic [STEP_W-1:0] MAX_V = STEP_W'(STEP_MAX);

    logic [STEP_W-1:0] step_q, step_d, leaked;
    logic [STEP_W:0]   grown;

    always_comb begin
        grown  = {1'b0, step_q} + INC_X;
        leaked = step_q - (step_q >> LEAK_SHIFT);
        if (run_i) step_d = (grown > MAX_X) ? MAX_V : grown[STEP_W-1:0];
        else       step_d = (leaked < MIN_V) ? MIN_V : leaked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     step_q <= MIN_V;
        else if (clr_i) step_q <= MIN_V;
        else if (upd_i) step_q <= step_d;
    end

    assign step_o = step_q;
endmodule

// File: rtl/sde_integrator.sv
module sde_integrator #(
    parameter int SAMPLE_W = 12,
    parameter int STEP_W   = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic                       upd_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic        [STEP_W-1:0]   step_i,
    output logic                       decide_o
);
    localparam int SUM_W = SAMPLE_W + 2;
    localparam logic signed [SUM_W-1:0] TOP_V = SUM_W'((1 << (SAMPLE_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] BOT_V = ~TOP_V;

    logic signed [SAMPLE_W-1:0] acc_q, acc_d;
    logic signed [SUM_W-1:0]    acc_x, step_x, sum;

    always_comb begin
        decide_o = (sample_i >= acc_q);
        acc_x    = {{2{acc_q[SAMPLE_W-1]}}, acc_q};
        step_x   = $signed({{(SUM_W-STEP_W){1'b0}}, step_i});
        sum      = decide_o ? (acc_x + step_x) : (acc_x - step_x);
        if (sum > TOP_V)      acc_d = TOP_V[SAMPLE_W-1:0];
        else if (sum < BOT_V) acc_d = BOT_V[SAMPLE_W-1:0];
        else                  acc_d = sum[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc_q <= '0;
        else if (clr_i) acc_q <= '0;
        else if (upd_i) acc_q <= acc_d;
    end
endmodule

// File: rtl/slope_delta_encoder.sv
module slope_delta_encoder
    import sde_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int STEP_MIN   = 16,
    parameter int STEP_MAX   = 1024,
    parameter int STEP_INC   = 64,
    parameter int LEAK_SHIFT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic                       run3_sel_i,
    input  logic                       idle_n_i,
    input  logic                       drive_en_i,
    input  logic                       awake_i,
    output logic                       pin_data_o,
    output logic                       pin_oe_o,
    output logic                       pin_low_o
);
    localparam int STEP_W   = $clog2(STEP_MAX + 1);
    localparam int RUN_LONG = 4;

    sde_state_e          state;
    logic                enc_fire, idle_fire, quiet;
    logic                decide, run_hit, bit_q, phase_q;
    logic [STEP_W-1:0]   step_cur;
    logic [RUN_LONG-1:0] run_fill;

    sde_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .awake_i(awake_i), .idle_n_i(idle_n_i),
        .tick_i(tick_i), .state_o(state), .enc_fire_o(enc_fire),
        .idle_fire_o(idle_fire), .quiet_o(quiet)
    );

    sde_run_detect #(.RUN_LONG(RUN_LONG)) u_run (
        .clk(clk), .rst_n(rst_n), .clr_i(state != ST_RUN), .shift_i(enc_fire),
        .bit_i(decide), .short_sel_i(run3_sel_i), .run_o(run_hit), .fill_o(run_fill)
    );

    sde_step_adapt #(
        .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX), .STEP_INC(STEP_INC),
        .LEAK_SHIFT(LEAK_SHIFT), .STEP_W(STEP_W)
    ) u_step (
        .clk(clk), .rst_n(rst_n), .clr_i(quiet), .upd_i(enc_fire),
        .run_i(run_hit), .step_o(step_cur)
    );

    sde_integrator #(.SAMPLE_W(SAMPLE_W), .STEP_W(STEP_W)) u_integ (
        .clk(clk), .rst_n(rst_n), .clr_i(quiet), .upd_i(enc_fire),
        .sample_i(sample_i), .step_i(step_cur), .decide_o(decide)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= 1'b0;
            phase_q <= 1'b0;
        end else if (quiet) begin
            bit_q   <= 1'b0;
            phase_q <= 1'b0;
        end else begin
            if (state != ST_IDLE) phase_q <= 1'b0;
            if (enc_fire) bit_q <= decide;
            if (idle_fire) begin
                bit_q   <= phase_q;
                phase_q <= ~phase_q;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_QUIET: begin
                pin_oe_o   = 1'b1;
                pin_low_o  = 1'b1;
                pin_data_o = 1'b0;
            end
            default: begin
                pin_oe_o   = drive_en_i;
                pin_low_o  = 1'b0;
                pin_data_o = drive_en_i & bit_q;
            end
        endcase
    end
endmodule

// File: rtl/sde_chk.sv
module sde_chk
    import sde_pkg::*;
#(
    parameter int STEP_MIN = 16,
    parameter int STEP_MAX = 1024,
    parameter int STEP_W   = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              awake_i,
    input logic              drive_en_i,
    input logic              tick_i,
    input sde_state_e        state,
    input logic              bit_q,
    input logic [STEP_W-1:0] step_cur,
    input logic [3:0]        run_fill,
    input logic              pin_data_o,
    input logic              pin_oe_o,
    input logic              pin_low_o
);
    // R8
    quiet_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !awake_i |=> (pin_low_o && pin_oe_o && !pin_data_o));

    // R7
    release_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (awake_i && $past(awake_i) && $past(rst_n) && !drive_en_i) |-> !pin_oe_o);

    // R4
    step_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(step_cur) >= STEP_MIN) && (32'(step_cur) <= STEP_MAX));

    // R1
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_QUIET && $past(state) != ST_QUIET && !$past(tick_i)) |-> $stable(bit_q));

    // R5
    idle_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> (run_fill == 4'b0000));
endmodule

bind slope_delta_encoder sde_chk #(
    .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX), .STEP_W(STEP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .awake_i(awake_i), .drive_en_i(drive_en_i),
    .tick_i(tick_i), .state(state), .bit_q(bit_q), .step_cur(step_cur),
    .run_fill(run_fill), .pin_data_o(pin_data_o), .pin_oe_o(pin_oe_o),
    .pin_low_o(pin_low_o)
);

// File: tb/sim_slope_delta_encoder.sv
`timescale 1ns/1ps
module sim_slope_delta_encoder;
    localparam int W    = 10;
    localparam int SMIN = 4;
    localparam int SMAX = 96;
    localparam int SINC = 24;
    localparam int LSH  = 2;
    localparam int HI   = (1 << (W-1)) - 1;
    localparam int LO   = -(1 << (W-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic signed [W-1:0] smp = '0;
    logic run3 = 1'b1, idle_n = 1'b1, den = 1'b1, awake = 1'b1;
    logic pdata, poe, plow;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    int m_integ, m_step;
    bit [3:0] m_hist, m_fill;
    bit m_bit, m_phase, m_idle;

    always #5 clk = ~clk;

    slope_delta_encoder #(
        .SAMPLE_W(W), .STEP_MIN(SMIN), .STEP_MAX(SMAX),
        .STEP_INC(SINC), .LEAK_SHIFT(LSH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .sample_i(smp),
        .run3_sel_i(run3), .idle_n_i(idle_n), .drive_en_i(den), .awake_i(awake),
        .pin_data_o(pdata), .pin_oe_o(poe), .pin_low_o(plow)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_integ = 0; m_step = SMIN; m_hist = '0; m_fill = '0;
        m_bit = 1'b0; m_phase = 1'b0;
    endtask

    function automatic bit run_seen(input bit [3:0] h, input bit [3:0] f, input bit sel);
        if (sel) return (f[2:0] == 3'b111) && (h[2:0] == 3'b000 || h[2:0] == 3'b111);
        return (f == 4'hF) && (h == 4'h0 || h == 4'hF);
    endfunction

    task automatic model_tick(input int s, input bit sel);
        bit b, r;
        if (m_idle) begin
            m_bit = m_phase; m_phase = !m_phase;
            return;
        end
        b = (s >= m_integ);
        m_hist = {m_hist[2:0], b};
        m_fill = {m_fill[2:0], 1'b1};
        r = run_seen(m_hist, m_fill, sel);
        m_integ = b ? m_integ + m_step : m_integ - m_step;
        if (m_integ > HI) m_integ = HI;
        if (m_integ < LO) m_integ = LO;
        if (r) m_step = (m_step + SINC > SMAX) ? SMAX : m_step + SINC;
        else   m_step = (m_step - (m_step >> LSH) < SMIN) ? SMIN : m_step - (m_step >> LSH);
        m_bit = b;
    endtask

    task automatic do_tick(input int s, input string req);
        @(negedge clk);
        smp = W'(s); tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick(s, run3);
        chk(pdata, den & m_bit, req);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd609));
        m_idle = 1'b0;
        model_clear();
        settle(3);
        // R9: reset holds the quiet state
        chk(poe, 1'b1, "R9 oe"); chk(plow, 1'b1, "R9 low"); chk(pdata, 1'b0, "R9 data");
        rst_n = 1'b1;
        settle(3);
        // R7: driven, not low, bit cleared
        chk(poe, 1'b1, "R7 oe"); chk(plow, 1'b0, "R7 low"); chk(pdata, 1'b0, "R8 cleared bit");

        // R2 R3 R4: full-scale ramp, step cap and integrator saturation
        for (int i = 0; i < 30; i++) do_tick(HI, "R2 R4 ramp up");
        for (int i = 0; i < 30; i++) do_tick(LO, "R2 R4 ramp down");
        do_tick(LO, "R2 saturated low");

        // R1 R3 R4: random samples, both run lengths, random gaps
        for (int i = 0; i < 400; i++) begin
            run3 = (i % 100) < 50;
            do_tick(int'($urandom_range(1023)) - 512, run3 ? "R3 run3 random" : "R3 run4 random");
            if ($urandom_range(3) == 0) begin
                smp = W'(int'($urandom_range(1023)) - 512);
                settle(2);
                chk(pdata, m_bit, "R1 hold without tick");
            end
        end

        // R3: slow tracking makes leak and short runs alternate
        for (int i = 0; i < 60; i++) do_tick((i % 12 < 6) ? 40 : -40, "R3 R4 square");

        // R5: idle pattern
        @(negedge clk); idle_n = 1'b0; settle(2);
        m_idle = 1'b1; m_phase = 1'b0; m_hist = '0; m_fill = '0;
        for (int i = 0; i < 8; i++) begin
            do_tick(HI, "R5 idle pattern");
            chk(pdata, (i % 2) == 1, "R5 alternation");
        end
        // R6: resume from held state with empty history
        @(negedge clk); idle_n = 1'b1; settle(2);
        m_idle = 1'b0;
        for (int i = 0; i < 40; i++) do_tick(int'($urandom_range(1023)) - 512, "R6 resume");

        // R7: released pin, encoding continues
        @(negedge clk); den = 1'b0; #1;
        chk(poe, 1'b0, "R7 released"); chk(pdata, 1'b0, "R7 data released");
        for (int i = 0; i < 10; i++) do_tick(int'($urandom_range(1023)) - 512, "R7 released data");
        @(negedge clk); den = 1'b1; #1;
        chk(pdata, m_bit, "R7 re-enabled bit");

        // R8: powersave
        @(negedge clk); awake = 1'b0; settle(2);
        chk(poe, 1'b1, "R8 oe"); chk(plow, 1'b1, "R8 low"); chk(pdata, 1'b0, "R8 data");
        @(negedge clk); tick = 1'b1; smp = W'(HI); @(negedge clk); tick = 1'b0;
        chk(pdata, 1'b0, "R8 tick ignored");
        @(negedge clk); awake = 1'b1; settle(2);
        model_clear();
        chk(plow, 1'b0, "R8 wake low");
        for (int i = 0; i < 40; i++) do_tick(int'($urandom_range(1023)) - 512, "R8 after wake");

        // R9: reset mid-stream
        @(negedge clk); rst_n = 1'b0; #1;
        chk(plow, 1'b1, "R9 async low");
        settle(2); rst_n = 1'b1; settle(2);
        model_clear();
        for (int i = 0; i < 40; i++) do_tick(int'($urandom_range(1023)) - 512, "R9 after reset");

        summary();
    end
endmodule